// File: doc/BRIEF.md
# Shared-Pointer Stack Window for Byte RAM

This block is a small register window that a CPU uses to reach a local byte-wide RAM through two data ports. Each port normally has its own address pointer that moves by one after every access, up or down as set by a per-port direction bit. Software can set a port pointer, then stream bytes in or out through that port without recomputing addresses.

A mode bit turns the pair of ports into a hardware stack. Both ports then share one pointer. A store to data port 0 writes the byte at the shared pointer and moves the pointer down by one. A load from data port 1 first moves the pointer up by one and then returns the byte there. A pop therefore always returns the most recently pushed byte, and software keeps no stack pointer of its own. The block holds a one-byte read-ahead for each port so that a load returns data in the same bus cycle. This works with a synchronous single-port RAM. After any data-port access or pointer change, the block spends three cycles refreshing both read-ahead bytes. The bus therefore leaves at least three idle cycles between accesses to registers 0 to 5.

Register offsets on `cpu_reg`: 0 pointer low byte, 1 pointer high bits, 2 direction, 3 mode, 4 data port 0, 5 data port 1, 6 shared-pointer low byte, 7 shared-pointer high bits. The pointer registers act on the port chosen by the mode register's select bit, except in stack mode, where they always act on the shared pointer.

Top module: `dps_stack_window`

## Requirements
- R1: After reset, both pointers are 0, the direction register (offset 2) and the mode register (offset 3) read 0, and offsets 6 and 7 read 0.
- R2: In normal mode, a read of a data port returns the byte at that port's pointer in the same cycle. The pointer then steps by one.
- R3: In normal mode, a write to a data port stores the byte at that port's pointer. The pointer then steps by one.
- R4: In normal mode, the two ports keep separate pointers. Accesses through one port leave the other port's pointer unchanged. Offsets 0 and 1 read or load the pointer of the port chosen by mode bit 0 (0 = port 0, 1 = port 1).
- R5: Direction bit 0 controls port 0 and bit 1 controls port 1. A value of 0 increments the pointer and 1 decrements it. Pointers wrap modulo 2^AW.
- R6: In stack mode (mode bit 1 = 1), a write to data port 0 stores the byte at the shared pointer and then decrements the shared pointer.
- R7: In stack mode, a read of data port 1 increments the shared pointer and returns the byte at the new pointer. Successive pops return pushed bytes in reverse order.
- R8: In stack mode, a read of data port 0 returns the top-of-stack byte and leaves the pointer unchanged. A write to data port 1 changes neither the RAM nor the pointer.
- R9: In stack mode, writes to offsets 0 and 1 load the shared pointer whatever the select bit. Offsets 6 and 7 always read the shared pointer, which is port 0's pointer in normal mode.
- R10: Clearing the stack bit copies the shared pointer into the pointers of both ports.
- R11: The shared pointer wraps modulo 2^AW on both push and pop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_cs | input | 1 | Bus access strobe, one cycle per access |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_reg | input | 3 | Register offset |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid in the access cycle |

## Verification
The bench tests several access patterns. Byte streams through one port and read back through the other separate independent pointers from a shared pointer. Decrementing runs that cross address zero expose wrap faults. Bursts of pushes followed by pops check last-in-first-out order and the ordering of pointer step and access. Pushes and pops mixed by a pseudo-random sequence show whether the read-ahead byte is refreshed after every stack change. Peeks, ignored port-1 writes and the exit from stack mode are each followed by pointer and data reads, which show whether these operations leave state unchanged or copy it.

// File: rtl/dps_pkg.sv
package dps_pkg;
   localparam int unsigned REG_W = 3;

   typedef enum logic [REG_W-1:0] {
      RG_PTR_LO = 3'd0,
      RG_PTR_HI = 3'd1,
      RG_DIR    = 3'd2,
      RG_MODE   = 3'd3,
      RG_PORT0  = 3'd4,
      RG_PORT1  = 3'd5,
      RG_SP_LO  = 3'd6,
      RG_SP_HI  = 3'd7
   } reg_e;

   typedef enum logic [1:0] {
      RF_IDLE = 2'd0,
      RF_RD0  = 2'd1,
      RF_RD1  = 2'd2,
      RF_CAP  = 2'd3
   } rf_state_e;
endpackage

// File: rtl/dps_ram.sv
module dps_ram #(
   parameter int unsigned AW = 10,
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] q
);
   localparam int unsigned DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         mem[addr] <= wdata;
      end else begin
         q <= mem[addr];
      end
   end
endmodule

// File: rtl/dps_ptr.sv
module dps_ptr #(
   parameter int unsigned AW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld,
   input  logic [AW-1:0] ld_val,
   input  logic          step,
   input  logic          dec,
   output logic [AW-1:0] ptr_q
);
   localparam logic [AW-1:0] ONE = AW'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (ld) begin
         ptr_q <= ld_val;
      end else if (step) begin
         ptr_q <= dec ? (ptr_q - ONE) : (ptr_q + ONE);
      end
   end
endmodule

// File: rtl/dps_refresh.sv
module dps_refresh
   import dps_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      kick,
   output rf_state_e state_q,
   output logic      cap0,
   output logic      cap1
);
   rf_state_e state_d;

   always_comb begin
      state_d = state_q;
      case (state_q)
         RF_IDLE: if (kick) state_d = RF_RD0;
         RF_RD0:  state_d = RF_RD1;
         RF_RD1:  state_d = RF_CAP;
         RF_CAP:  state_d = RF_IDLE;
         default: state_d = RF_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= RF_IDLE;
      else        state_q <= state_d;
   end

   assign cap0 = (state_q == RF_RD1);
   assign cap1 = (state_q == RF_CAP);

   // the two read-ahead bytes are never captured in the same cycle (R2)
   p_cap_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cap0 |=> cap1);
endmodule

// File: rtl/dps_stack_window.sv
module dps_stack_window
   import dps_pkg::*;
#(
   parameter int unsigned AW = 10,
   parameter int unsigned DW = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cpu_cs,
   input  logic         cpu_we,
   input  logic [2:0]   cpu_reg,
   input  logic [7:0]   cpu_wdata,
   output logic [7:0]   cpu_rdata
);
   localparam int unsigned NPORT = 2;
   localparam int unsigned HI_W  = AW - 8;
   typedef logic [AW-1:0] ptr_t;
   localparam ptr_t ONE = AW'(1);

   generate
      if (AW < 9 || AW > 16) begin : g_bad_aw
         $error("dps_stack_window: AW must lie in 9..16");
      end
      if (DW != 8) begin : g_bad_dw
         $error("dps_stack_window: DW must be 8");
      end
   endgenerate

   // control state
   logic             stack_q, sel_q;
   logic [NPORT-1:0] dir_q;
   logic [DW-1:0]    pf_q [NPORT];

   // decode
   logic acc_wr, acc_rd, hit0, hit1, addr_wr, leave, mode_wr, dir_wr, kick;
   logic tgt;
   ptr_t new_ptr, base_ptr;

   logic [NPORT-1:0] ld, step, dec;
   ptr_t             ld_val [NPORT];
   ptr_t             ptr_q  [NPORT];
   ptr_t             eff    [NPORT];

   assign acc_wr  = cpu_cs &  cpu_we;
   assign acc_rd  = cpu_cs & ~cpu_we;
   assign hit0    = cpu_cs && (cpu_reg == RG_PORT0);
   assign hit1    = cpu_cs && (cpu_reg == RG_PORT1);
   assign addr_wr = acc_wr && (cpu_reg == RG_PTR_LO || cpu_reg == RG_PTR_HI);
   assign mode_wr = acc_wr && (cpu_reg == RG_MODE);
   assign dir_wr  = acc_wr && (cpu_reg == RG_DIR);
   assign leave   = mode_wr && stack_q && !cpu_wdata[1];
   assign tgt     = stack_q ? 1'b0 : sel_q;
   assign kick    = addr_wr || mode_wr || hit0 || hit1;

   assign base_ptr = ptr_q[tgt];

   always_comb begin
      if (cpu_reg == RG_PTR_LO) new_ptr = {base_ptr[AW-1:8], cpu_wdata};
      else                      new_ptr = {cpu_wdata[HI_W-1:0], base_ptr[7:0]};
   end

   // per-port pointer controls
   always_comb begin
      ld[0]     = addr_wr && !tgt;
      ld_val[0] = new_ptr;
      if (stack_q) begin
         step[0] = (hit0 && cpu_we) || (hit1 && !cpu_we);
         dec[0]  = hit0;
      end else begin
         step[0] = hit0;
         dec[0]  = dir_q[0];
      end
      ld[1]     = (addr_wr && tgt) || leave;
      ld_val[1] = leave ? ptr_q[0] : new_ptr;
      step[1]   = !stack_q && hit1;
      dec[1]    = dir_q[1];
   end

   generate
      for (genvar gi = 0; gi < NPORT; gi++) begin : g_port
         dps_ptr #(.AW(AW)) u_ptr (
            .clk    (clk),
            .rst_n  (rst_n),
            .ld     (ld[gi]),
            .ld_val (ld_val[gi]),
            .step   (step[gi]),
            .dec    (dec[gi]),
            .ptr_q  (ptr_q[gi])
         );
         assign eff[gi] = stack_q ? (ptr_q[0] + ONE) : ptr_q[gi];
      end
   endgenerate

   // control registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stack_q <= 1'b0;
         sel_q   <= 1'b0;
         dir_q   <= '0;
      end else begin
         if (mode_wr) begin
            sel_q   <= cpu_wdata[0];
            stack_q <= cpu_wdata[1];
         end
         if (dir_wr) dir_q <= cpu_wdata[NPORT-1:0];
      end
   end

   // refresh sequencer and RAM
   rf_state_e rf_state;
   logic      cap0, cap1;

   dps_refresh u_refresh (
      .clk     (clk),
      .rst_n   (rst_n),
      .kick    (kick),
      .state_q (rf_state),
      .cap0    (cap0),
      .cap1    (cap1)
   );

   logic          ram_we;
   ptr_t          ram_addr;
   logic [DW-1:0] ram_q;

   assign ram_we = acc_wr && (hit0 || (hit1 && !stack_q));

   always_comb begin
      case (rf_state)
         RF_RD0:  ram_addr = eff[0];
         RF_RD1:  ram_addr = eff[1];
         default: ram_addr = hit1 ? ptr_q[1] : ptr_q[0];
      endcase
   end

   dps_ram #(.AW(AW), .DW(DW)) u_ram (
      .clk   (clk),
      .we    (ram_we),
      .addr  (ram_addr),
      .wdata (cpu_wdata),
      .q     (ram_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pf_q[0] <= '0;
         pf_q[1] <= '0;
      end else begin
         if (cap0) pf_q[0] <= ram_q;
         if (cap1) pf_q[1] <= ram_q;
      end
   end

   // read mux
   always_comb begin
      case (cpu_reg)
         RG_PTR_LO: cpu_rdata = base_ptr[7:0];
         RG_PTR_HI: cpu_rdata = 8'(base_ptr >> 8);
         RG_DIR:    cpu_rdata = 8'(dir_q);
         RG_MODE:   cpu_rdata = {6'd0, stack_q, sel_q};
         RG_PORT0:  cpu_rdata = pf_q[0];
         RG_PORT1:  cpu_rdata = pf_q[1];
         RG_SP_LO:  cpu_rdata = ptr_q[0][7:0];
         default:   cpu_rdata = 8'(ptr_q[0] >> 8);
      endcase
   end

   // assertions
   p_push_dec_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (stack_q && acc_wr && cpu_reg == RG_PORT0) |=> ptr_q[0] == ptr_t'($past(ptr_q[0]) - ONE));

   p_pop_inc_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (stack_q && acc_rd && cpu_reg == RG_PORT1) |=> ptr_q[0] == ptr_t'($past(ptr_q[0]) + ONE));

   p_peek_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (stack_q && ((acc_rd && cpu_reg == RG_PORT0) || (acc_wr && cpu_reg == RG_PORT1)))
      |=> $stable(ptr_q[0]) && $stable(ptr_q[1]));

   p_leave_copy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (stack_q && acc_wr && cpu_reg == RG_MODE && !cpu_wdata[1]) |=> ptr_q[1] == ptr_q[0]);

   p_port_indep_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!stack_q && cpu_reg == RG_PORT0) |=> $stable(ptr_q[1]));

   p_stack_no_ram_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (stack_q && cpu_reg == RG_PORT1) |-> !ram_we);
endmodule

// File: tb/dps_stack_window_tb.sv
`timescale 1ns/1ps
module dps_stack_window_tb_top;
   localparam int AW = 10;
   localparam int N  = 1 << AW;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cpu_cs = 1'b0, cpu_we = 1'b0;
   logic [2:0] cpu_reg = '0;
   logic [7:0] cpu_wdata = '0;
   logic [7:0] cpu_rdata;

   always #10 clk = ~clk;

   dps_stack_window #(.AW(AW)) dut_i (
      .clk(clk), .rst_n(rst_n), .cpu_cs(cpu_cs), .cpu_we(cpu_we),
      .cpu_reg(cpu_reg), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata)
   );

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   // behavioural reference
   int m [N];
   int p [2];
   int dr [2];
   int stk, sel;

   function automatic int stepf(int x, int d);
      return d ? (x + N - 1) % N : (x + 1) % N;
   endfunction

   function automatic int model_rd(int r);
      int t = stk ? 0 : sel;
      int v = 0;
      case (r)
         0: v = p[t] & 255;
         1: v = (p[t] >> 8) & 255;
         2: v = dr[1] * 2 + dr[0];
         3: v = stk * 2 + sel;
         4: if (stk) v = m[(p[0] + 1) % N];
            else begin v = m[p[0]]; p[0] = stepf(p[0], dr[0]); end
         5: if (stk) begin p[0] = (p[0] + 1) % N; v = m[p[0]]; end
            else begin v = m[p[1]]; p[1] = stepf(p[1], dr[1]); end
         6: v = p[0] & 255;
         default: v = (p[0] >> 8) & 255;
      endcase
      return v;
   endfunction

   function automatic void model_wr(int r, int d);
      int t = stk ? 0 : sel;
      case (r)
         0: p[t] = (p[t] & ~255) | d;
         1: p[t] = ((d << 8) | (p[t] & 255)) % N;
         2: begin dr[0] = d & 1; dr[1] = (d >> 1) & 1; end
         3: begin
               if (stk != 0 && (d & 2) == 0) p[1] = p[0];
               sel = d & 1; stk = (d >> 1) & 1;
            end
         4: begin
               m[p[0]] = d;
               p[0] = stk ? (p[0] + N - 1) % N : stepf(p[0], dr[0]);
            end
         5: if (stk == 0) begin m[p[1]] = d; p[1] = stepf(p[1], dr[1]); end
         default: ;
      endcase
   endfunction

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(int r, int d);
      @(negedge clk);
      cpu_cs = 1; cpu_we = 1; cpu_reg = 3'(r); cpu_wdata = 8'(d);
      model_wr(r, d & 255);
      @(negedge clk);
      cpu_cs = 0; cpu_we = 0;
      repeat (3) @(negedge clk);
   endtask

   task automatic rd(int r, string req);
      int exp;
      @(negedge clk);
      cpu_cs = 1; cpu_we = 0; cpu_reg = 3'(r);
      exp = model_rd(r);
      #1;
      if (exp >= 0) check(req, int'(cpu_rdata), exp);
      @(negedge clk);
      cpu_cs = 0;
      repeat (3) @(negedge clk);
   endtask

   task automatic set_ptr(int v);
      wr(0, v & 255);
      wr(1, (v >> 8) & 255);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      bit [15:0] lfsr = 16'hACE1;
      int depth = 0;
      for (int i = 0; i < N; i++) m[i] = -1;
      p[0] = 0; p[1] = 0; dr[0] = 0; dr[1] = 0; stk = 0; sel = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1 reset state
      rd(3, "R1 mode"); rd(2, "R1 dir"); rd(6, "R1 sp lo"); rd(7, "R1 sp hi");
      rd(0, "R1 ptr lo");

      // R3 normal writes through port 0, R2/R4 read back via port 1
      set_ptr(12'h010);
      for (int i = 0; i < 4; i++) wr(4, 8'hA0 + i);
      rd(6, "R3 ptr0 stepped"); rd(7, "R3 ptr0 hi");
      wr(3, 1);
      set_ptr(12'h010);
      for (int i = 0; i < 4; i++) rd(5, "R2 port1 read");
      rd(0, "R4 port1 ptr lo");
      wr(3, 0);
      rd(0, "R4 port0 ptr untouched");

      // R5 decrement with wrap through zero, read back with increment
      wr(2, 1);
      set_ptr(1);
      for (int i = 0; i < 3; i++) wr(4, 8'h51 + i);
      rd(0, "R5 ptr0 wrapped lo"); rd(1, "R5 ptr0 wrapped hi");
      wr(3, 1);
      set_ptr(N - 1);
      for (int i = 0; i < 3; i++) rd(5, "R5 inc wrap read");
      wr(2, 3);
      set_ptr(12'h013);
      for (int i = 0; i < 4; i++) rd(5, "R5 port1 dec read");
      wr(2, 0);
      wr(3, 0);

      // R6/R7/R8/R9 stack mode
      wr(3, 3);
      rd(3, "R9 mode reads stack");
      set_ptr(12'h200);
      rd(6, "R9 sp lo loaded"); rd(7, "R9 sp hi loaded");
      for (int i = 0; i < 5; i++) wr(4, 8'hC0 + i);
      rd(6, "R6 sp after pushes"); rd(7, "R6 sp hi");
      rd(4, "R8 peek"); rd(4, "R8 peek again"); rd(6, "R8 peek keeps sp");
      wr(5, 8'hEE);
      rd(6, "R8 port1 write keeps sp");
      for (int i = 0; i < 5; i++) rd(5, "R7 pop order");
      rd(6, "R7 sp restored"); rd(7, "R7 sp hi");

      // R11 wrap of shared pointer
      set_ptr(0);
      wr(4, 8'h11); wr(4, 8'h22);
      rd(6, "R11 sp wrapped lo"); rd(7, "R11 sp wrapped hi");
      rd(5, "R11 pop"); rd(5, "R11 pop"); rd(6, "R11 sp back");

      // mixed pushes and pops
      set_ptr(12'h300);
      for (int i = 0; i < 40; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         if (depth == 0 || lfsr[0]) begin
            wr(4, int'(lfsr[15:8])); depth++;
         end else begin
            rd(5, "R7 mixed pop"); depth--;
         end
         rd(4, "R6 mixed top");
      end
      rd(6, "R6 mixed sp");

      // R10 leaving stack mode copies pointer
      set_ptr(12'h123);
      wr(3, 1);
      rd(0, "R10 port1 ptr lo"); rd(1, "R10 port1 ptr hi");
      wr(3, 0);
      rd(0, "R10 port0 ptr lo"); rd(1, "R10 port0 ptr hi");

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule